// File: doc/BRIEF.md
# UART Interrupt Source Identifier

This block sits between the condition flags of a UART and its host-facing interrupt line. It holds the 8-bit interrupt enable register. It masks eight pending conditions with that register and drives an active-low interrupt output. It also presents an identification value that names the single most urgent enabled source.

The logic that raises each condition lies outside this block. Every condition except transmit room is taken as a level and is reported for as long as it stays high. Transmit room is different: it is armed on an edge and disarmed when the host reads the identification value while transmit is the reported source. The host writes the enable register through a write strobe. The upper four enable bits accept a write only while the extended-features input is high.

Top module: `uirq_ident`

## Requirements
- R1: After reset the enable register reads 0x00, the identification value reads 0x01 and `irq_n` is high.
- R2: A write to the enable register always updates bits 3:0. It updates bits 7:4 only when `ext_en` is 1; otherwise those bits keep their value.
- R3: `irq_n` is 0 exactly when at least one enabled source is pending.
- R4: Bit 0 of the identification value is 0 while an interrupt is pending and 1 otherwise. With nothing pending the value is 0x01. Bits 7:6 always read 0.
- R5: Each source has an enable bit and a code in bits 5:0. Line error uses enable bit 2 and code 0x06. Receive timeout uses bit 0 and code 0x0C. Receive level uses bit 0 and code 0x04. Transmit room uses bit 1 and code 0x02. Modem change uses bit 3 and code 0x00. GPIO change uses bit 3 and code 0x30. XOFF uses bit 5 and code 0x10. CTS/RTS change uses bit 6 or bit 7 and code 0x20.
- R6: When several enabled sources are pending, only the highest one is reported. The order from highest to lowest is: line error, receive timeout, receive level, transmit room, modem, GPIO, XOFF, CTS/RTS.
- R7: The transmit-room source arms in two cases: `c_tx_room` rises while enable bit 1 is set, or enable bit 1 becomes set while `c_tx_room` is high. It disarms whenever `c_tx_room` is low. It is reported only while enable bit 1 is set.
- R8: A read strobe in a cycle where the reported code is 0x02 disarms the transmit-room source from the next cycle on. A read strobe while another source is reported leaves the transmit-room source unchanged.
- R9: Enable bit 4 (sleep) has no effect on `irq_n` or the identification value.
- R10: The CTS/RTS source is enabled by bit 6 alone, by bit 7 alone, or by both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| c_line_err | input | 1 | Line status error pending |
| c_rx_tmo | input | 1 | Receive timeout pending |
| c_rx_lvl | input | 1 | Receive data at trigger level |
| c_tx_room | input | 1 | Transmit holding space at trigger level |
| c_modem | input | 1 | Modem status change |
| c_gpio | input | 1 | GPIO pin change |
| c_xoff | input | 1 | XOFF character received |
| c_flow | input | 1 | CTS or RTS change |
| iie_we | input | 1 | Enable register write strobe |
| iie_wdata | input | 8 | Enable register write data |
| ext_en | input | 1 | Extended features on (unlocks enable bits 7:4) |
| iid_rd | input | 1 | Identification value read strobe |
| irq_n | output | 1 | Interrupt, active low |
| iid | output | 8 | Identification value |
| iie | output | 8 | Enable register contents |

## Verification
The functions that can fall in the same cycle are the read-to-clear of the transmit-room source and the arrival of a higher-priority source. If a line error appears in the cycle the host reads, the reported code is 0x06. That read must therefore leave transmit room armed, and code 0x02 must come back once the error goes away. The bench provokes this collision on purpose. It also sets up a read that coincides with an enable register write and with `c_tx_room` falling. The behavioural model compares `iid`, `irq_n` and `iie` on every cycle, so it judges each cycle after the collision.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int NSRC = 8;
  localparam int CODE_W = 6;
  localparam int THR_IDX = 3;

  // source index equals priority rank (0 = most urgent)
  function automatic logic [CODE_W-1:0] src_code(input int unsigned k);
    case (k)
      0: return 6'h06;
      1: return 6'h0C;
      2: return 6'h04;
      3: return 6'h02;
      4: return 6'h00;
      5: return 6'h30;
      6: return 6'h10;
      default: return 6'h20;
    endcase
  endfunction

  function automatic logic src_gate(input int unsigned k, input logic [7:0] en);
    case (k)
      0: return en[2];
      1, 2: return en[0];
      3: return en[1];
      4, 5: return en[3];
      6: return en[5];
      default: return en[6] | en[7];
    endcase
  endfunction
endpackage

// File: rtl/uirq_en_reg.sv
module uirq_en_reg #(
  parameter int DW = 8,
  parameter int LOCK_LSB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  input  logic          unlock,
  output logic [DW-1:0] q
);
  localparam int HI_W = DW - LOCK_LSB;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (we) begin
      q[LOCK_LSB-1:0] <= wdata[LOCK_LSB-1:0];
      if (unlock) q[DW-1:LOCK_LSB] <= wdata[DW-1:LOCK_LSB];
    end
  end

  p_hi_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !unlock) |=> (q[DW-1:LOCK_LSB] == $past(q[DW-1:LOCK_LSB])));

  logic [HI_W-1:0] unused_w;
  assign unused_w = '0;
endmodule

// File: rtl/uirq_thr_arm.sv
module uirq_thr_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic room,
  input  logic en,
  input  logic clr,
  output logic pend
);
  logic room_d, en_d;
  logic room_rise, en_rise, pend_nx;

  assign room_rise = room & ~room_d & en;
  assign en_rise   = en & ~en_d & room;
  assign pend_nx   = room & ((pend & ~clr) | room_rise | en_rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      room_d <= 1'b0;
      en_d   <= 1'b0;
      pend   <= 1'b0;
    end else begin
      room_d <= room;
      en_d   <= en;
      pend   <= pend_nx;
    end
  end

  p_needs_room_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> $past(room));
  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !pend);
endmodule

// File: rtl/uirq_pick.sv
module uirq_pick #(
  parameter int N = 8
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         hit
);
  logic [N:0] blk;
  assign blk[0] = 1'b0;

  for (genvar gi = 0; gi < N; gi++) begin : g_rank
    assign grant[gi]  = req[gi] & ~blk[gi];
    assign blk[gi+1]  = blk[gi] | req[gi];
  end

  assign hit = blk[N];
endmodule

// File: rtl/uirq_ident.sv
module uirq_ident
  import uirq_pkg::*;
#(
  parameter int IE_W = 8,
  parameter int IE_LOCK_LSB = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            c_line_err,
  input  logic            c_rx_tmo,
  input  logic            c_rx_lvl,
  input  logic            c_tx_room,
  input  logic            c_modem,
  input  logic            c_gpio,
  input  logic            c_xoff,
  input  logic            c_flow,
  input  logic            iie_we,
  input  logic [IE_W-1:0] iie_wdata,
  input  logic            ext_en,
  input  logic            iid_rd,
  output logic            irq_n,
  output logic [7:0]      iid,
  output logic [IE_W-1:0] iie
);
  logic [NSRC-1:0]   raw, req, grant;
  logic              hit, thr_pend, thr_clr;
  logic [CODE_W-1:0] code;

  uirq_en_reg #(.DW(IE_W), .LOCK_LSB(IE_LOCK_LSB)) u_en (
    .clk(clk), .rst_n(rst_n), .we(iie_we), .wdata(iie_wdata),
    .unlock(ext_en), .q(iie)
  );

  assign thr_clr = iid_rd & grant[THR_IDX];

  uirq_thr_arm u_thr (
    .clk(clk), .rst_n(rst_n), .room(c_tx_room), .en(iie[1]),
    .clr(thr_clr), .pend(thr_pend)
  );

  assign raw = {c_flow, c_xoff, c_gpio, c_modem, thr_pend, c_rx_lvl, c_rx_tmo, c_line_err};

  for (genvar gk = 0; gk < NSRC; gk++) begin : g_mask
    assign req[gk] = raw[gk] & src_gate(gk, iie[7:0]);
  end

  uirq_pick #(.N(NSRC)) u_pick (.req(req), .grant(grant), .hit(hit));

  always_comb begin
    code = '0;
    for (int k = 0; k < NSRC; k++)
      if (grant[k]) code = code | src_code(k);
  end

  assign iid   = {2'b00, code} | {7'b0, ~hit};
  assign irq_n = ~hit;

  p_idle_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n |-> (iid == 8'h01));
  p_one_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  p_line_err_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (c_line_err && iie[2]) |-> (iid[5:0] == 6'h06));
  p_pending_drives_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|raw[2:0] && iie[0] && iie[2]) |-> !irq_n);
endmodule

// File: tb/sim_uirq_ident.sv
module sim_uirq_ident;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic le = 0, tmo = 0, rxl = 0, txr = 0, mdm = 0, gp = 0, xf = 0, fl = 0;
  logic we = 0, ext = 0, rd = 0;
  logic [7:0] wd = 0;
  logic irq_n;
  logic [7:0] iid, iie;

  int checks = 0, fails = 0;
  string tag = "R1";

  uirq_ident u0 (
    .clk(clk), .rst_n(rst_n), .c_line_err(le), .c_rx_tmo(tmo), .c_rx_lvl(rxl),
    .c_tx_room(txr), .c_modem(mdm), .c_gpio(gp), .c_xoff(xf), .c_flow(fl),
    .iie_we(we), .iie_wdata(wd), .ext_en(ext), .iid_rd(rd),
    .irq_n(irq_n), .iid(iid), .iie(iie)
  );

  always #(PERIOD/2) clk = ~clk;

  // behavioural reference state
  logic [7:0] m_ier = 0;
  bit m_tx = 0, m_psp = 0, m_pen = 0;
  int codes[8] = '{6, 12, 4, 2, 0, 48, 16, 32};

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    bit pend[8];
    int best;
    int e_iid;
    if (!rst_n) begin
      m_ier = 0; m_tx = 0; m_psp = 0; m_pen = 0;
    end
    pend[0] = le  && m_ier[2];
    pend[1] = tmo && m_ier[0];
    pend[2] = rxl && m_ier[0];
    pend[3] = m_tx && m_ier[1];
    pend[4] = mdm && m_ier[3];
    pend[5] = gp  && m_ier[3];
    pend[6] = xf  && m_ier[5];
    pend[7] = fl  && (m_ier[6] || m_ier[7]);
    best = -1;
    for (int k = 7; k >= 0; k--) if (pend[k]) best = k;
    e_iid = (best < 0) ? 1 : codes[best];
    chk("iid", int'(iid), e_iid);
    chk("irq_n", int'(irq_n), (best < 0) ? 1 : 0);
    chk("iie", int'(iie), int'(m_ier));
    if (rst_n) begin
      bit keep, arm;
      keep = m_tx && !(rd && best == 3);
      arm  = (txr && !m_psp && m_ier[1]) || (m_ier[1] && !m_pen && txr);
      m_psp = txr;
      m_pen = m_ier[1];
      m_tx  = txr && (keep || arm);
      if (we) begin
        m_ier[3:0] = wd[3:0];
        if (ext) m_ier[7:4] = wd[7:4];
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr_ie(logic [7:0] v, logic unlock);
    we = 1; wd = v; ext = unlock; tick(); we = 0; ext = 0;
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_up();
  end

  initial begin
    tag = "R1"; tick(3); rst_n = 1; tick(2);
    chk("reset iid", int'(iid), 1);

    tag = "R2";
    wr_ie(8'hFF, 0); tick();
    chk("locked hi", int'(iie), 8'h0F);
    wr_ie(8'hF0, 1); tick();
    wr_ie(8'h05, 0); tick();
    chk("hi kept", int'(iie), 8'hF5);

    tag = "R5"; wr_ie(8'h00, 1);
    wr_ie(8'h04, 0); le = 1; tick(2); le = 0;
    wr_ie(8'h01, 0); tmo = 1; tick(2); tmo = 0; rxl = 1; tick(2); rxl = 0;
    wr_ie(8'h08, 0); mdm = 1; tick(2); mdm = 0; gp = 1; tick(2); gp = 0;
    wr_ie(8'h20, 1); xf = 1; tick(2); xf = 0;

    tag = "R10";
    wr_ie(8'h40, 1); fl = 1; tick(2);
    wr_ie(8'h80, 1); tick(2);
    wr_ie(8'hC0, 1); tick(2);
    wr_ie(8'h30, 1); tick(2); fl = 0;

    tag = "R6";
    wr_ie(8'hEF, 1);
    le = 1; tmo = 1; rxl = 1; mdm = 1; gp = 1; xf = 1; fl = 1; txr = 1; tick(2);
    chk("top code", int'(iid), 8'h06);
    le = 0; tick(); tmo = 0; tick(); rxl = 0; tick(); rd = 1; tick(); rd = 0;
    mdm = 0; tick(); gp = 0; tick(); xf = 0; tick(); fl = 0; tick();

    tag = "R7";
    txr = 0; tick(); txr = 1; tick();
    chk("tx armed", int'(iid), 8'h02);
    txr = 0; tick(); chk("tx gone", int'(irq_n), 1);
    wr_ie(8'h00, 1); txr = 1; tick(2); wr_ie(8'h02, 0); tick();
    chk("en rise arms", int'(iid), 8'h02);

    tag = "R8";
    le = 1; wr_ie(8'h06, 0); rd = 1; tick(); rd = 0; le = 0; tick();
    chk("tx survives", int'(iid), 8'h02);
    rd = 1; tick(); rd = 0; tick();
    chk("tx cleared", int'(irq_n), 1);
    txr = 0; tick(); txr = 1; rd = 1; we = 1; wd = 8'h03; tick(); rd = 0; we = 0;
    rd = 1; txr = 0; tick(); rd = 0; tick(2);

    tag = "R9";
    wr_ie(8'h10, 1); rxl = 1; tick(2);
    chk("sleep only", int'(irq_n), 1);
    wr_ie(8'h11, 1); tick(2); rxl = 0; tick();

    tag = "R3";
    wr_ie(8'hFF, 1);
    for (int i = 0; i < 400; i++) begin
      {le, tmo, rxl, txr, mdm, gp, xf, fl} = 8'($urandom);
      rd = $urandom_range(0, 1);
      we = ($urandom_range(0, 7) == 0); wd = 8'($urandom); ext = $urandom_range(0, 1);
      tick();
    end
    {le, tmo, rxl, txr, mdm, gp, xf, fl} = 0; rd = 0; we = 0; ext = 0;
    tick(3);
    tag = "R4"; chk("idle", int'(iid), 1);
    finish_up();
  end
endmodule